// File: doc/BRIEF.md
# Read-Once Secret Word Store

This block keeps a device secret, fixed by a parameter, as a set of separately addressed words behind a small read port. A requester raises a select strobe with a word index. One cycle later the block returns the word and a ready pulse. Each word is handed out at most once between resets, and the words may be read in any order.

Every access is gated by a privilege enable input. The surrounding system drives this input low whenever the processor is not running trusted boot code, and that includes the time spent servicing system calls. While the enable is low, or when a word has already been handed out, a read returns zero and the stored state does not change. Writes to the port are ignored. A per-word spent vector is brought out so that the consumption state can be observed directly.

Top module: `secret_vault`

## Requirements
- R1: While reset is held, and right after it, `ready` is 0, `rdata` is 0 and all bits of `spent` are 0.
- R2: A read (`sel`=1, `wr`=0) with `priv_en`=1 to a word whose `spent` bit is 0 returns that word in `rdata` on the next cycle. Word i is bits [32*i+31 : 32*i] of the SECRET parameter.
- R3: `ready` is 1 in the cycle after every cycle with `sel`=1, for reads and writes alike, and is 0 in the cycle after every cycle with `sel`=0.
- R4: An honoured read sets only the `spent` bit whose index equals `addr`. The bit is visible on the next cycle. No other event sets a bit.
- R5: A read of a word whose `spent` bit is already 1 returns 0 and leaves `spent` unchanged.
- R6: Any access while `priv_en`=0 returns 0 and leaves `spent` unchanged. A word that was blocked this way can still be read later, once `priv_en` is 1.
- R7: Words can be consumed in any index order, and each word's data is independent of the order in which the words are read.
- R8: An access with `wr`=1 returns 0 and leaves `spent` unchanged.
- R9: `spent` bits never clear except on reset. A reset makes every word readable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| priv_en | input | 1 | Privilege enable; access is honoured only when high |
| sel | input | 1 | Access strobe |
| wr | input | 1 | Write qualifier; writes are ignored |
| addr | input | ADDR_W (3) | Word index |
| rdata | output | WORD_W (32) | Registered read data, zero unless a read was honoured |
| ready | output | 1 | Access completion, one cycle after `sel` |
| spent | output | N_WORDS (8) | Per-word consumed flags |

## Verification
On every cycle the assertions check the following:
- the `ready` timing;
- that `spent` only ever gains bits, and at most one bit per cycle;
- that blocked reads, repeated reads and writes return zero and leave `spent` unchanged;
- that `spent` stays unchanged when the port is idle.

Only the bench scenarios can show the rest:
- that an honoured read returns the correct parameter slice, for indices taken out of order;
- that a word blocked by a low enable or by a write can still be read later;
- that a reset in the middle of a run restores every word.

// File: rtl/secret_vault_pkg.sv
package secret_vault_pkg;

   // Outcome of one access cycle at the port.
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_GRANT = 2'd1,
      ACC_BLOCK = 2'd2
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic sel, input logic wr,
                                          input logic en, input logic used);
      if (!sel)
         return ACC_IDLE;
      else if (!wr && en && !used)
         return ACC_GRANT;
      else
         return ACC_BLOCK;
   endfunction

endpackage

// File: rtl/vault_word_mux.sv
module vault_word_mux #(
   parameter int N_WORDS = 8,
   parameter int WORD_W  = 32,
   parameter logic [N_WORDS*WORD_W-1:0] SECRET = '0,
   localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word
);

   logic [WORD_W-1:0] words [N_WORDS];

   for (genvar i = 0; i < N_WORDS; i++) begin : g_slice
      assign words[i] = SECRET[i*WORD_W +: WORD_W];
   end

   if (N_WORDS == 1) begin : g_single
      assign word = words[0];
   end else begin : g_multi
      assign word = words[idx];
   end

endmodule

// File: rtl/vault_spent_flags.sv
module vault_spent_flags #(
   parameter int N_WORDS = 8,
   localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mark,
   input  logic [IDX_W-1:0]   mark_idx,
   output logic [N_WORDS-1:0] flags
);

   for (genvar i = 0; i < N_WORDS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (mark && mark_idx == IDX_W'(i))
            flags[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/secret_vault.sv
module secret_vault
   import secret_vault_pkg::*;
#(
   parameter int N_WORDS = 8,
   parameter int WORD_W  = 32,
   parameter logic [N_WORDS*WORD_W-1:0] SECRET =
      256'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c834_1082_276b_f3a2_7251_f86c_6a11_d0c1_8e95,
   localparam int ADDR_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               priv_en,
   input  logic               sel,
   input  logic               wr,
   input  logic [ADDR_W-1:0]  addr,
   output logic [WORD_W-1:0]  rdata,
   output logic               ready,
   output logic [N_WORDS-1:0] spent
);

   // Elaboration checks: every index must decode to a real word.
   if (N_WORDS < 1) begin : g_bad_count
      $error("secret_vault: N_WORDS must be at least 1");
   end
   if (N_WORDS > 1 && (1 << ADDR_W) != N_WORDS) begin : g_bad_pow2
      $error("secret_vault: N_WORDS must be a power of two");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("secret_vault: WORD_W must be at least 1");
   end

   acc_kind_e         kind;
   logic [WORD_W-1:0] sel_word;
   logic              word_used;

   assign word_used = spent[addr];
   assign kind      = classify(sel, wr, priv_en, word_used);

   vault_word_mux #(
      .N_WORDS(N_WORDS),
      .WORD_W (WORD_W),
      .SECRET (SECRET)
   ) u_mux (
      .idx (addr),
      .word(sel_word)
   );

   vault_spent_flags #(
      .N_WORDS(N_WORDS)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .mark    (kind == ACC_GRANT),
      .mark_idx(addr),
      .flags   (spent)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         ready <= 1'b0;
      end else begin
         ready <= sel;
         rdata <= (kind == ACC_GRANT) ? sel_word : '0;
      end
   end

endmodule

// File: rtl/secret_vault_checks.sv
module secret_vault_checks #(
   parameter int N_WORDS = 8,
   parameter int WORD_W  = 32,
   parameter int ADDR_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               priv_en,
   input logic               sel,
   input logic               wr,
   input logic [ADDR_W-1:0]  addr,
   input logic [WORD_W-1:0]  rdata,
   input logic               ready,
   input logic [N_WORDS-1:0] spent
);

   assert_ready_after_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel |=> ready);

   assert_ready_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !ready);

   assert_spent_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (spent & $past(spent)) == $past(spent));

   assert_single_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(spent ^ $past(spent)) <= 1);

   assert_idle_no_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(spent));

   assert_reread_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && spent[addr]) |=> (rdata == '0 && $stable(spent)));

   assert_locked_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !priv_en) |=> (rdata == '0 && $stable(spent)));

   assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr) |=> (rdata == '0 && $stable(spent)));

endmodule

bind secret_vault secret_vault_checks #(
   .N_WORDS(N_WORDS),
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_checks (
   .clk    (clk),
   .rst_n  (rst_n),
   .priv_en(priv_en),
   .sel    (sel),
   .wr     (wr),
   .addr   (addr),
   .rdata  (rdata),
   .ready  (ready),
   .spent  (spent)
);

// File: tb/secret_vault_test.sv
module secret_vault_test;

   localparam logic [255:0] TB_SECRET =
      256'h7777_1111_6666_2222_5555_3333_4444_4444_3333_5555_2222_6666_1111_7777_0f0f_8888;

   // Step encoding: {en, wr, addr[2:0], expect_data}
   localparam int NSTEP = 13;
   localparam logic [5:0] STEPS [NSTEP] = '{
      {1'b1, 1'b0, 3'd5, 1'b1},  // R2 R7 out-of-order first read
      {1'b1, 1'b0, 3'd5, 1'b0},  // R5 repeat read blank
      {1'b0, 1'b0, 3'd2, 1'b0},  // R6 enable low
      {1'b1, 1'b1, 3'd2, 1'b0},  // R8 write ignored
      {1'b1, 1'b0, 3'd2, 1'b1},  // R6 R8 word still available
      {1'b1, 1'b0, 3'd0, 1'b1},  // R2
      {1'b1, 1'b0, 3'd7, 1'b1},  // R7
      {1'b0, 1'b0, 3'd7, 1'b0},  // R6
      {1'b1, 1'b0, 3'd3, 1'b1},  // R7
      {1'b1, 1'b0, 3'd1, 1'b1},  // R7
      {1'b1, 1'b0, 3'd6, 1'b1},  // R7
      {1'b1, 1'b0, 3'd4, 1'b1},  // R7
      {1'b1, 1'b0, 3'd4, 1'b0}   // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv_en = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] rdata;
   logic        ready;
   logic [7:0]  spent;

   int checks = 0;
   int errors = 0;
   logic [7:0] model_spent = '0;

   always #2 clk = ~clk;

   secret_vault #(.SECRET(TB_SECRET)) uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .priv_en(priv_en),
      .sel    (sel),
      .wr     (wr),
      .addr   (addr),
      .rdata  (rdata),
      .ready  (ready),
      .spent  (spent)
   );

   function automatic logic [31:0] word_of(input int i);
      return TB_SECRET[i*32 +: 32];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic en, input logic w, input logic [2:0] a);
      @(negedge clk);
      priv_en = en; wr = w; addr = a; sel = 1'b1;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ready in reset", {31'd0, ready}, 32'd0);
      check("R1 rdata in reset", rdata, 32'd0);
      check("R1 spent in reset", {24'd0, spent}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 spent after reset", {24'd0, spent}, 32'd0);
      check("R3 ready idle", {31'd0, ready}, 32'd0);

      for (int i = 0; i < NSTEP; i++) begin
         logic [5:0] s;
         logic [31:0] exp_data;
         s = STEPS[i];
         access(s[5], s[4], s[3:1]);
         exp_data = s[0] ? word_of(int'(s[3:1])) : 32'd0;
         if (s[0]) model_spent[s[3:1]] = 1'b1;
         check($sformatf("R2/R5/R6/R7/R8 data step %0d", i), rdata, exp_data);
         check($sformatf("R3 ready step %0d", i), {31'd0, ready}, 32'd1);
         check($sformatf("R4 spent step %0d", i), {24'd0, spent}, {24'd0, model_spent});
      end

      @(negedge clk);
      check("R3 ready drops after idle", {31'd0, ready}, 32'd0);
      check("R9 all words spent", {24'd0, spent}, 32'h0000_00ff);

      // Reset in the middle of a run restores every word.
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 reset clears spent", {24'd0, spent}, 32'd0);
      rst_n = 1'b1;
      access(1'b1, 1'b0, 3'd5);
      check("R9 reread after reset", rdata, word_of(5));
      check("R4 single bit after reset", {24'd0, spent}, 32'h0000_0020);
      access(1'b0, 1'b1, 3'd0);
      check("R6 R8 locked write blank", rdata, 32'd0);
      check("R8 locked write spent", {24'd0, spent}, 32'h0000_0020);

      finish_run();
   end

endmodule